// File: doc/BRIEF.md
# Hot-Plug Slot Event Notifier

This block holds the slot control and slot status registers of a downstream port that supports hot-plug. Software reaches both registers through one 32-bit configuration word. Slot control occupies byte lanes 0 and 1, and slot status occupies byte lanes 2 and 3. Each lane has its own byte enable.

Hardware events set sticky bits in slot status. There are three of them:
- the attention button was pressed;
- the presence detect state changed;
- a slot control command completed.

Software clears these bits by writing ones to them. A write of one to the interlock command bit flips the interlock status bit.

The block keeps a single registered notify term: the hot-plug interrupt enable, ANDed with any event bit that is both pending and enabled. With message signalling off, a level interrupt line follows that term. With message signalling on, the block sends a one-cycle message request each time the term rises. A port reset input clears the three event bits and leaves the control register and the interlock status unchanged.

Top module: `hp_slot_notifier`

## Requirements
- R1: After `rst_n` is low for a clock edge, `cfg_rdata` reads 0, and both `intx` and `msi_req` are low.
- R2: Slot control is `cfg_rdata[15:0]`. Only bits 0 (attention enable), 3 (presence enable), 4 (command-done enable) and 5 (hot-plug interrupt enable) are stored, each from the write lane that carries it. All other control bits read 0. A write whose `cfg_be[1:0]` is 0 leaves slot control unchanged.
- R3: A write with any of `cfg_be[1:0]` set sets the command-done status bit (`cfg_rdata[20]`). A write with `cfg_be[1:0]` equal to 0 does not set it.
- R4: A pulse on `evt_attn` sets status bit 0 (`cfg_rdata[16]`), and a pulse on `evt_presence` sets status bit 3 (`cfg_rdata[19]`). Both bits are set on the next edge and stay set.
- R5: Writing a one to status bits 0, 3 or 4 with `cfg_be[2]` set clears that bit. Ones written to any other status bit have no effect. If an event and a clear hit the same bit in the same cycle, the event wins.
- R6: Writing control bit 11 as one with `cfg_be[1]` set flips status bit 7 (`cfg_rdata[23]`). Control bit 11 always reads 0.
- R7: The notify term is control bit 5 ANDed with the OR over bits 0, 3 and 4 of (status AND control). It is registered one edge after the registers change. With `msi_enable` low, `intx` equals that registered term.
- R8: With `msi_enable` high, `intx` stays low. `msi_req` is high for exactly one cycle after the notify term rises from false to true. A fall of the term produces no request.
- R9: An event that arrives while its enables are off raises `intx` or `msi_req` later, at the moment software sets the matching enables.
- R10: An event whose status bit is already set produces no new `msi_req` pulse.
- R11: A pulse on `port_rst` clears status bits 0, 3 and 4 and keeps slot control and status bit 7. The notify term is re-evaluated, so `intx` drops on the following edge. A reset wins over an event in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| port_rst | input | 1 | Port reset pulse; clears the event status bits |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_be | input | 4 | Byte enables: lanes 0-1 control, lanes 2-3 status |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | {slot status, slot control} |
| evt_attn | input | 1 | Attention button press pulse |
| evt_presence | input | 1 | Presence detect change pulse |
| msi_enable | input | 1 | Selects message signalling instead of the level line |
| msi_req | output | 1 | One-cycle message request |
| intx | output | 1 | Level interrupt line |

## Verification
The main sweep runs with the level line selected. It covers all 16 combinations of the four control enables crossed with all 8 combinations of pending event bits, so the enable/status AND and the hot-plug interrupt gate are each separated from a plain OR of the pending bits.

Directed sequences cover the message path separately:
- an event that arrives while masked and is then unmasked tells late delivery apart from lost delivery;
- a repeated event on a bit that is already set tells edge firing apart from level firing;
- a clear followed by a fresh event tells a rise of the term apart from a fall.

Further sequences separate control-lane writes from status-lane writes. They also check the interlock flip, a clear that lands in the same cycle as an event, and a port reset that must keep the control register.

// File: rtl/hp_slot_pkg.sv
package hp_slot_pkg;
   // Default layout of the two slot registers
   localparam int unsigned HP_REG_W   = 16;
   localparam int unsigned HP_ABP_BIT = 0;
   localparam int unsigned HP_PDC_BIT = 3;
   localparam int unsigned HP_CC_BIT  = 4;
   localparam int unsigned HP_EIS_BIT = 7;
   localparam int unsigned HP_HPE_BIT = 5;
   localparam int unsigned HP_EIC_BIT = 11;

   // Single-bit mask helper for elaboration-time constants
   function automatic logic [31:0] hp_bit(input int unsigned pos);
      logic [31:0] m;
      m = '0;
      m[pos] = 1'b1;
      return m;
   endfunction
endpackage

// File: rtl/hp_ctrl_reg.sv
module hp_ctrl_reg #(
   parameter int unsigned REG_W   = 16,
   parameter logic [REG_W-1:0] RW_MASK = 16'h0039,
   parameter int unsigned EIC_BIT = 11
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [REG_W/8-1:0] be,
   input  logic [REG_W-1:0] wdata,
   output logic [REG_W-1:0] ctrl_q,
   output logic             ctrl_wr,
   output logic             eic_pulse
);
   localparam int unsigned NBYTES  = REG_W / 8;
   localparam int unsigned EIC_LANE = EIC_BIT / 8;

   // One register lane per byte enable
   for (genvar b = 0; b < NBYTES; b++) begin : g_lane
      logic [7:0] lane_q;
      always_ff @(posedge clk) begin
         if (!rst_n)
            lane_q <= '0;
         else if (wr_en && be[b])
            lane_q <= wdata[b*8 +: 8] & RW_MASK[b*8 +: 8];
      end
      assign ctrl_q[b*8 +: 8] = lane_q;
   end

   // Any overlap with the control lanes counts as a command
   assign ctrl_wr   = wr_en && (|be);
   // Interlock command is a strobe only; it is never stored
   assign eic_pulse = wr_en && be[EIC_LANE] && wdata[EIC_BIT];
endmodule

// File: rtl/hp_status_reg.sv
module hp_status_reg #(
   parameter int unsigned REG_W   = 16,
   parameter logic [REG_W-1:0] EVT_MASK = 16'h0019,
   parameter int unsigned EIS_BIT = 7,
   parameter bit          HAS_INTERLOCK = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             port_rst,
   input  logic [REG_W-1:0] evt_set,
   input  logic [REG_W-1:0] w1c,
   input  logic             eis_toggle,
   output logic [REG_W-1:0] sts_q
);
   for (genvar i = 0; i < REG_W; i++) begin : g_bit
      if (EVT_MASK[i]) begin : g_evt
         // Sticky event: port reset > new event > software clear
         logic bit_q;
         always_ff @(posedge clk) begin
            if (!rst_n)
               bit_q <= 1'b0;
            else if (port_rst)
               bit_q <= 1'b0;
            else if (evt_set[i])
               bit_q <= 1'b1;
            else if (w1c[i])
               bit_q <= 1'b0;
         end
         assign sts_q[i] = bit_q;
      end else if (HAS_INTERLOCK && (i == EIS_BIT)) begin : g_eis
         // Interlock state flips on command, survives port reset
         logic bit_q;
         always_ff @(posedge clk) begin
            if (!rst_n)
               bit_q <= 1'b0;
            else if (eis_toggle)
               bit_q <= ~bit_q;
         end
         assign sts_q[i] = bit_q;
      end else begin : g_zero
         assign sts_q[i] = 1'b0;
      end
   end
endmodule

// File: rtl/hp_notify_core.sv
module hp_notify_core #(
   parameter int unsigned REG_W    = 16,
   parameter logic [REG_W-1:0] EVT_MASK = 16'h0019,
   parameter int unsigned HPE_BIT  = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [REG_W-1:0] ctrl,
   input  logic [REG_W-1:0] sts,
   input  logic             msi_enable,
   output logic             intx,
   output logic             msi_req
);
   logic notify_d;
   logic notify_q;
   logic msi_q;

   // Enabled-and-pending term gated by the master enable
   assign notify_d = ctrl[HPE_BIT] && (|(sts & ctrl & EVT_MASK));

   // Re-evaluated every cycle; message only on a rising term
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         notify_q <= 1'b0;
         msi_q    <= 1'b0;
      end else begin
         notify_q <= notify_d;
         msi_q    <= msi_enable && notify_d && !notify_q;
      end
   end

   assign intx    = notify_q && !msi_enable;
   assign msi_req = msi_q;
endmodule

// File: rtl/hp_slot_notifier.sv
module hp_slot_notifier
   import hp_slot_pkg::*;
#(
   parameter int unsigned REG_W    = HP_REG_W,
   parameter int unsigned ABP_BIT  = HP_ABP_BIT,
   parameter int unsigned PDC_BIT  = HP_PDC_BIT,
   parameter int unsigned CC_BIT   = HP_CC_BIT,
   parameter int unsigned EIS_BIT  = HP_EIS_BIT,
   parameter int unsigned HPE_BIT  = HP_HPE_BIT,
   parameter int unsigned EIC_BIT  = HP_EIC_BIT,
   parameter logic [15:0] CTRL_RW_MASK = 16'h0039,
   parameter bit          HAS_INTERLOCK = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 port_rst,
   input  logic                 cfg_wr,
   input  logic [REG_W/4-1:0]   cfg_be,
   input  logic [2*REG_W-1:0]   cfg_wdata,
   output logic [2*REG_W-1:0]   cfg_rdata,
   input  logic                 evt_attn,
   input  logic                 evt_presence,
   input  logic                 msi_enable,
   output logic                 msi_req,
   output logic                 intx
);
   localparam int unsigned NBYTES = REG_W / 8;
   localparam logic [31:0] EVT_MASK32 =
      hp_bit(ABP_BIT) | hp_bit(PDC_BIT) | hp_bit(CC_BIT);
   localparam logic [REG_W-1:0] EVT_MASK = EVT_MASK32[REG_W-1:0];
   localparam logic [REG_W-1:0] RW_MASK  = CTRL_RW_MASK[REG_W-1:0];

   // Elaboration-time parameter checks
   if ((REG_W % 8) != 0 || REG_W > 32) begin : g_bad_w
      $error("REG_W must be a multiple of 8 and at most 32");
   end
   if (EIC_BIT >= REG_W || HPE_BIT >= REG_W || EIS_BIT >= REG_W) begin : g_bad_pos
      $error("bit position outside register");
   end
   if (CTRL_RW_MASK[EIC_BIT]) begin : g_bad_eic
      $error("interlock command bit must not be storable");
   end
   if (ABP_BIT == PDC_BIT || ABP_BIT == CC_BIT || PDC_BIT == CC_BIT) begin : g_bad_evt
      $error("event bit positions must be distinct");
   end
   if (EVT_MASK[EIS_BIT]) begin : g_bad_eis
      $error("interlock status must not be an event bit");
   end

   logic [REG_W-1:0] ctrl_q;
   logic [REG_W-1:0] sts_q;
   logic [REG_W-1:0] evt_set;
   logic [REG_W-1:0] w1c;
   logic             ctrl_wr;
   logic             eic_pulse;

   hp_ctrl_reg #(
      .REG_W   (REG_W),
      .RW_MASK (RW_MASK),
      .EIC_BIT (EIC_BIT)
   ) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (cfg_wr),
      .be        (cfg_be[NBYTES-1:0]),
      .wdata     (cfg_wdata[REG_W-1:0]),
      .ctrl_q    (ctrl_q),
      .ctrl_wr   (ctrl_wr),
      .eic_pulse (eic_pulse)
   );

   // Event set vector: two hardware sources plus command completion
   always_comb begin
      evt_set          = '0;
      evt_set[ABP_BIT] = evt_attn;
      evt_set[PDC_BIT] = evt_presence;
      evt_set[CC_BIT]  = ctrl_wr;
   end

   // Write-one-to-clear strobes from the status lanes
   for (genvar b = 0; b < NBYTES; b++) begin : g_w1c
      assign w1c[b*8 +: 8] = (cfg_wr && cfg_be[NBYTES+b]) ?
                             cfg_wdata[REG_W + b*8 +: 8] : 8'h00;
   end

   hp_status_reg #(
      .REG_W         (REG_W),
      .EVT_MASK      (EVT_MASK),
      .EIS_BIT       (EIS_BIT),
      .HAS_INTERLOCK (HAS_INTERLOCK)
   ) u_sts (
      .clk        (clk),
      .rst_n      (rst_n),
      .port_rst   (port_rst),
      .evt_set    (evt_set),
      .w1c        (w1c),
      .eis_toggle (eic_pulse),
      .sts_q      (sts_q)
   );

   hp_notify_core #(
      .REG_W    (REG_W),
      .EVT_MASK (EVT_MASK),
      .HPE_BIT  (HPE_BIT)
   ) u_notify (
      .clk        (clk),
      .rst_n      (rst_n),
      .ctrl       (ctrl_q),
      .sts        (sts_q),
      .msi_enable (msi_enable),
      .intx       (intx),
      .msi_req    (msi_req)
   );

   assign cfg_rdata = {sts_q, ctrl_q};
endmodule

// File: rtl/hp_slot_notifier_chk.sv
module hp_slot_notifier_chk #(
   parameter int unsigned REG_W   = 16,
   parameter int unsigned ABP_BIT = 0,
   parameter int unsigned PDC_BIT = 3,
   parameter int unsigned CC_BIT  = 4
) (
   input logic               clk,
   input logic               rst_n,
   input logic               port_rst,
   input logic               cfg_wr,
   input logic [REG_W/4-1:0] cfg_be,
   input logic [2*REG_W-1:0] cfg_rdata,
   input logic               evt_attn,
   input logic               msi_enable,
   input logic               msi_req,
   input logic               intx
);
   localparam int unsigned NBYTES = REG_W / 8;

   AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(cfg_wr && (|cfg_be[NBYTES-1:0])) |=> $stable(cfg_rdata[REG_W-1:0])); // R2
   AST_CMD_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_wr && (|cfg_be[NBYTES-1:0]) && !port_rst) |=> cfg_rdata[REG_W+CC_BIT]); // R3
   AST_ATTN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_attn && !port_rst) |=> cfg_rdata[REG_W+ABP_BIT]); // R4
   AST_INTX_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      msi_enable |-> !intx); // R8
   AST_MSI_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      msi_req |=> !msi_req); // R8
   AST_MSI_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
      msi_req |-> $past(msi_enable)); // R8
   AST_PORT_RST: assert property (@(posedge clk) disable iff (!rst_n)
      port_rst |=> !(cfg_rdata[REG_W+ABP_BIT] || cfg_rdata[REG_W+PDC_BIT]
                     || cfg_rdata[REG_W+CC_BIT])); // R11
endmodule

bind hp_slot_notifier hp_slot_notifier_chk #(
   .REG_W   (REG_W),
   .ABP_BIT (ABP_BIT),
   .PDC_BIT (PDC_BIT),
   .CC_BIT  (CC_BIT)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .port_rst   (port_rst),
   .cfg_wr     (cfg_wr),
   .cfg_be     (cfg_be),
   .cfg_rdata  (cfg_rdata),
   .evt_attn   (evt_attn),
   .msi_enable (msi_enable),
   .msi_req    (msi_req),
   .intx       (intx)
);

// File: tb/tb_hp_slot_notifier.sv
`timescale 1ns/1ps
module tb_hp_slot_notifier;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        port_rst = 1'b0;
   logic        cfg_wr = 1'b0;
   logic [3:0]  cfg_be = '0;
   logic [31:0] cfg_wdata = '0;
   logic [31:0] cfg_rdata;
   logic        evt_attn = 1'b0;
   logic        evt_presence = 1'b0;
   logic        msi_enable = 1'b0;
   logic        msi_req;
   logic        intx;

   int n_cmp = 0;
   int n_bad = 0;

   always #4 clk = ~clk;   // 125 MHz

   hp_slot_notifier dut (
      .clk(clk), .rst_n(rst_n), .port_rst(port_rst),
      .cfg_wr(cfg_wr), .cfg_be(cfg_be), .cfg_wdata(cfg_wdata),
      .cfg_rdata(cfg_rdata), .evt_attn(evt_attn),
      .evt_presence(evt_presence), .msi_enable(msi_enable),
      .msi_req(msi_req), .intx(intx)
   );

   task automatic chk(input logic [31:0] act, input logic [31:0] exp,
                      input string tag);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // One cycle of stimulus, driven at the falling edge
   task automatic cyc(input logic wr, input logic [3:0] be,
                      input logic [31:0] d, input logic a,
                      input logic p, input logic pr);
      @(negedge clk);
      cfg_wr = wr; cfg_be = be; cfg_wdata = d;
      evt_attn = a; evt_presence = p; port_rst = pr;
      @(negedge clk);
      cfg_wr = 1'b0; cfg_be = '0; cfg_wdata = '0;
      evt_attn = 1'b0; evt_presence = 1'b0; port_rst = 1'b0;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      logic [15:0] ctl;
      logic [15:0] sts;
      logic        exp_i;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      chk(cfg_rdata, 32'h0, "R1 rdata");
      chk({31'b0, intx}, 32'h0, "R1 intx");
      chk({31'b0, msi_req}, 32'h0, "R1 msi_req");

      // R7 sweep: every enable set against every pending-event set
      for (int e = 0; e < 16; e++) begin
         for (int p = 0; p < 8; p++) begin
            ctl = (e[0] ? 16'h0001 : 16'h0) | (e[1] ? 16'h0008 : 16'h0) |
                  (e[2] ? 16'h0010 : 16'h0) | (e[3] ? 16'h0020 : 16'h0);
            sts = (p[0] ? 16'h0001 : 16'h0) | (p[1] ? 16'h0008 : 16'h0) |
                  (p[2] ? 16'h0010 : 16'h0);
            cyc(1'b1, 4'b0011, {16'h0, ctl}, 1'b0, 1'b0, 1'b0);
            cyc(1'b0, 4'b0000, 32'h0, 1'b0, 1'b0, 1'b1);
            cyc(1'b0, 4'b0000, 32'h0, p[0], p[1], 1'b0);
            if (p[2]) cyc(1'b1, 4'b0011, {16'h0, ctl}, 1'b0, 1'b0, 1'b0);
            idle(2);
            exp_i = e[3] && (|(ctl & sts & 16'h0019));
            chk(cfg_rdata, {sts, ctl}, "R7 sweep rdata (R2 R3 R4)");
            chk({31'b0, intx}, {31'b0, exp_i}, "R7 sweep intx");
         end
      end

      // R2 / R6 / R3: storable bits only, interlock flip, command done
      cyc(1'b1, 4'b0000, 32'h0, 1'b0, 1'b0, 1'b1);
      cyc(1'b1, 4'b0011, 32'h0000_FFFF, 1'b0, 1'b0, 1'b0);
      chk(cfg_rdata, 32'h0090_0039, "R2 R6 full control write");
      // R5: clear command done through the status lane; ones elsewhere ignored
      cyc(1'b1, 4'b0100, 32'h00FF_0000, 1'b0, 1'b0, 1'b0);
      chk(cfg_rdata, 32'h0080_0039, "R5 w1c and R2 no control change");
      // R6: flip interlock back with the upper control lane only
      cyc(1'b1, 4'b0010, 32'h0000_0800, 1'b0, 1'b0, 1'b0);
      chk(cfg_rdata, 32'h0010_0039, "R6 interlock toggle back");
      // R5: event wins over a same-cycle clear
      cyc(1'b1, 4'b0100, 32'h0001_0000, 1'b1, 1'b0, 1'b0);
      chk(cfg_rdata, 32'h0011_0039, "R5 event beats clear");

      // R9 / R8 on the message path
      msi_enable = 1'b1;
      cyc(1'b1, 4'b0011, 32'h0, 1'b0, 1'b0, 1'b0);
      cyc(1'b0, 4'b0000, 32'h0, 1'b0, 1'b0, 1'b1);
      idle(2);
      cyc(1'b0, 4'b0000, 32'h0, 1'b1, 1'b0, 1'b0);
      chk({31'b0, msi_req}, 32'h0, "R9 masked event no request");
      @(negedge clk);
      chk({31'b0, msi_req}, 32'h0, "R9 masked event still quiet");
      cyc(1'b1, 4'b0011, 32'h0000_0021, 1'b0, 1'b0, 1'b0);
      chk({31'b0, msi_req}, 32'h0, "R8 request not before term");
      @(negedge clk);
      chk({31'b0, msi_req}, 32'h1, "R9 request on unmask");
      chk({31'b0, intx}, 32'h0, "R8 intx low with msi");
      @(negedge clk);
      chk({31'b0, msi_req}, 32'h0, "R8 single cycle");
      // R10: repeated event on an already-set bit
      cyc(1'b0, 4'b0000, 32'h0, 1'b1, 1'b0, 1'b0);
      for (int i = 0; i < 3; i++) begin
         chk({31'b0, msi_req}, 32'h0, "R10 no repeat request");
         @(negedge clk);
      end
      // R8: falling term gives nothing, fresh event gives a pulse
      cyc(1'b1, 4'b0100, 32'h0001_0000, 1'b0, 1'b0, 1'b0);
      @(negedge clk);
      chk({31'b0, msi_req}, 32'h0, "R8 no request on fall");
      cyc(1'b0, 4'b0000, 32'h0, 1'b1, 1'b0, 1'b0);
      @(negedge clk);
      chk({31'b0, msi_req}, 32'h1, "R8 request on new rise");

      // R11: port reset keeps control and interlock, drops intx
      msi_enable = 1'b0;
      cyc(1'b1, 4'b0010, 32'h0000_0800, 1'b0, 1'b0, 1'b0);
      idle(1);
      chk({31'b0, intx}, 32'h1, "R7 intx level before port reset");
      cyc(1'b0, 4'b0000, 32'h0, 1'b1, 1'b0, 1'b1);
      chk(cfg_rdata, 32'h0080_0021, "R11 port reset state");
      @(negedge clk);
      chk({31'b0, intx}, 32'h0, "R11 intx dropped");

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule